// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Interrupts

This peripheral drives and samples a parameterised number of general-purpose pins, grouped into 32-pin register sets. Software uses a plain word-addressed register bus to do four things:
- steer each pin's direction;
- raise or lower individual output bits without a read-modify-write;
- read back a synchronised copy of every pin level;
- arm per-pin rising-edge and falling-edge detection.

Enabled edges latch into a sticky status word per register set, which software clears by writing ones.

Each 32-pin set is split into two 16-pin interrupt banks. The low half-word forms the even bank and the high half-word the odd bank. A bank drives its own interrupt line when its bit in a global bank-enable register is set and any status bit in its half-word is pending. Pin levels enter through a two-flop synchroniser, and edges are found by comparing consecutive synchronised samples.

The register bus has no back-pressure. A write is taken on the clock edge where `bus_wen` is high. A read is taken on the edge where `bus_ren` is high, and its data appears on `bus_rdata` with `bus_rvalid` one cycle later.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset every direction bit reads 1 (input), every output bit, edge enable, status bit and bank enable reads 0, and `pin_oe`, `pin_out` and `bank_irq` are all 0.
- R2: The bank-enable register sits at byte address 0x08. Register set s starts at 0x10 + 0x28*s and holds ten words at word offsets 0..9: direction, output value, set-output, clear-output, input level, set-rise-enable, clear-rise-enable, set-fall-enable, clear-fall-enable, edge status. A read issued in one cycle returns its data with `bus_rvalid` high in the next cycle.
- R3: A direction bit of 1 makes the pin an input (`pin_oe` low); a direction bit of 0 makes it an output (`pin_oe` high).
- R4: Writing the output-value word replaces all 32 output bits. Writing ones to set-output drives those bits high. Writing ones to clear-output drives them low. Zero bits leave outputs unchanged. Both words read back the current output value.
- R5: The input-level word returns `pin_in` after two synchronising flops, whatever the pin's direction. A pin change before clock edge k is returned by a read captured at edge k+2, and not by reads captured at edges k or k+1. Writes to this word are ignored.
- R6: Rise and fall enables change only through their write-one-to-set and write-one-to-clear words. Each word of a pair reads back the current enable mask, and a pin may have both edges enabled.
- R7: A synchronised 0-to-1 change on a pin with its rise enable set, or a 1-to-0 change with its fall enable set, sets that pin's status bit. A change in a direction that is not enabled sets nothing.
- R8: Writing 1 to a status bit clears it, and zero bits are unaffected. When an enabled edge and the clearing write land in the same cycle, the bit stays set.
- R9: `bank_irq[n]` covers pins 16n..16n+15, which is set n/2, low half-word for even n and high half-word for odd n. It is high exactly when bank-enable bit n is 1 and a status bit in that half-word is 1.
- R10: Writes to addresses that decode to no register (unaligned, in the gap below 0x10, or beyond the last set) change nothing, and reads from them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wen | input | 1 | Write strobe, taken on the rising clock edge |
| bus_ren | input | 1 | Read strobe, taken on the rising clock edge |
| bus_addr | input | ADDR_W | Byte address of the accessed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while `bus_rvalid` is high |
| bus_rvalid | output | 1 | High one cycle after an accepted read |
| pin_in | input | 32*NUM_SETS | Pin levels, asynchronous to `clk` |
| pin_out | output | 32*NUM_SETS | Output values |
| pin_oe | output | 32*NUM_SETS | Output enable, high for output pins |
| bank_irq | output | 2*NUM_SETS | One interrupt line per 16-pin bank |

## Verification
The assertions assume the bus strobes are clean single-cycle pulses with valid addresses, and that outputs, enables and status are only touched by bus writes or by detected edges. The bench keeps within this in two ways. It drives every strobe and address on the falling clock edge, and it changes `pin_in` only on falling edges. So the synchroniser sees each pin change at a known rising edge, and the bench can place a clearing write on exactly the cycle an edge reaches the status word. Status bits are checked only after the three-cycle path from pin to status has elapsed.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int SET_PINS     = 32;
  localparam int BANK_PINS    = 16;
  localparam int BANK_EN_ADDR = 8;
  localparam int SET_BASE     = 16;
  localparam int SET_STRIDE   = 40;
  localparam int SET_WORDS    = 10;

  // word index inside one register set; the order is the software-visible layout
  typedef enum logic [3:0] {
    W_DIR  = 4'd0,
    W_OUT  = 4'd1,
    W_SETO = 4'd2,
    W_CLRO = 4'd3,
    W_IN   = 4'd4,
    W_SETR = 4'd5,
    W_CLRR = 4'd6,
    W_SETF = 4'd7,
    W_CLRF = 4'd8,
    W_STAT = 4'd9
  } word_e;
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
    end
  end

  assign sync_o = sync_q;
endmodule

// File: rtl/gpio_edge_det.sv
module gpio_edge_det #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] level_i,
  input  logic [W-1:0] rise_en_i,
  input  logic [W-1:0] fall_en_i,
  output logic [W-1:0] hit_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= level_i;
  end

  assign hit_o = (level_i & ~prev_q & rise_en_i) | (~level_i & prev_q & fall_en_i);
endmodule

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_bank_pkg::*;
#(
  parameter int NUM_SETS = 2,
  parameter int ADDR_W   = 8,
  parameter int SEL_W    = 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_bank_en_o,
  output logic              hit_set_o,
  output logic [SEL_W-1:0]  set_idx_o,
  output word_e             word_o
);
  int unsigned a_int;

  always_comb begin
    a_int         = 32'(addr_i);
    hit_bank_en_o = (a_int == BANK_EN_ADDR);
    hit_set_o     = 1'b0;
    set_idx_o     = '0;
    word_o        = W_DIR;
    for (int s = 0; s < NUM_SETS; s++) begin
      if (a_int >= 32'(SET_BASE + SET_STRIDE * s) &&
          a_int <  32'(SET_BASE + SET_STRIDE * s + 4 * SET_WORDS) &&
          a_int[1:0] == 2'b00) begin
        hit_set_o = 1'b1;
        set_idx_o = SEL_W'(s);
        word_o    = word_e'(4'((a_int - 32'(SET_BASE + SET_STRIDE * s)) >> 2));
      end
    end
  end
endmodule

// File: rtl/gpio_reg_set.sv
module gpio_reg_set
  import gpio_bank_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en_i,
  input  word_e               word_i,
  input  logic [31:0]         wr_data_i,
  output logic [31:0]         rd_data_o,
  input  logic [SET_PINS-1:0] pin_sync_i,
  output logic [SET_PINS-1:0] dir_o,
  output logic [SET_PINS-1:0] out_o,
  output logic [SET_PINS-1:0] rise_o,
  output logic [SET_PINS-1:0] fall_o,
  output logic [SET_PINS-1:0] stat_o
);
  logic [SET_PINS-1:0] dir_q, out_q, rise_q, fall_q, stat_q;
  logic [SET_PINS-1:0] edge_hit;
  logic [SET_PINS-1:0] stat_clr;

  gpio_edge_det #(.W(SET_PINS)) edge_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .level_i   (pin_sync_i),
    .rise_en_i (rise_q),
    .fall_en_i (fall_q),
    .hit_o     (edge_hit)
  );

  assign stat_clr = (wr_en_i && word_i == W_STAT) ? wr_data_i : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '1;
      out_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
      stat_q <= '0;
    end else begin
      // a fresh edge outranks a clear of the same bit
      stat_q <= (stat_q & ~stat_clr) | edge_hit;
      if (wr_en_i) begin
        unique case (word_i)
          W_DIR:  dir_q  <= wr_data_i;
          W_OUT:  out_q  <= wr_data_i;
          W_SETO: out_q  <= out_q | wr_data_i;
          W_CLRO: out_q  <= out_q & ~wr_data_i;
          W_SETR: rise_q <= rise_q | wr_data_i;
          W_CLRR: rise_q <= rise_q & ~wr_data_i;
          W_SETF: fall_q <= fall_q | wr_data_i;
          W_CLRF: fall_q <= fall_q & ~wr_data_i;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    unique case (word_i)
      W_DIR:                rd_data_o = dir_q;
      W_OUT, W_SETO, W_CLRO: rd_data_o = out_q;
      W_IN:                 rd_data_o = pin_sync_i;
      W_SETR, W_CLRR:       rd_data_o = rise_q;
      W_SETF, W_CLRF:       rd_data_o = fall_q;
      W_STAT:               rd_data_o = stat_q;
      default:              rd_data_o = '0;
    endcase
  end

  assign dir_o  = dir_q;
  assign out_o  = out_q;
  assign rise_o = rise_q;
  assign fall_o = fall_q;
  assign stat_o = stat_q;
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int NUM_SETS = 2,
  parameter int ADDR_W   = 8,
  localparam int PINS    = SET_PINS * NUM_SETS,
  localparam int BANKS   = PINS / BANK_PINS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wen,
  input  logic              bus_ren,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  input  logic [PINS-1:0]   pin_in,
  output logic [PINS-1:0]   pin_out,
  output logic [PINS-1:0]   pin_oe,
  output logic [BANKS-1:0]  bank_irq
);
  localparam int SEL_W = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1;

  logic              hit_bank_en, hit_set;
  logic [SEL_W-1:0]  set_idx;
  word_e             word;
  logic [PINS-1:0]   pin_sync;
  logic [PINS-1:0]   dir_all, rise_all, fall_all, status_all;
  logic [31:0]       set_rd [NUM_SETS];
  logic [BANKS-1:0]  bank_en_q;
  logic [31:0]       rdata_q;
  logic              rvalid_q;

  gpio_addr_dec #(.NUM_SETS(NUM_SETS), .ADDR_W(ADDR_W), .SEL_W(SEL_W)) dec_i (
    .addr_i        (bus_addr),
    .hit_bank_en_o (hit_bank_en),
    .hit_set_o     (hit_set),
    .set_idx_o     (set_idx),
    .word_o        (word)
  );

  gpio_pin_sync #(.W(PINS)) sync_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (pin_in),
    .sync_o  (pin_sync)
  );

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    logic set_wr;
    assign set_wr = bus_wen && hit_set && (set_idx == SEL_W'(s));
    gpio_reg_set set_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en_i    (set_wr),
      .word_i     (word),
      .wr_data_i  (bus_wdata),
      .rd_data_o  (set_rd[s]),
      .pin_sync_i (pin_sync[s*SET_PINS +: SET_PINS]),
      .dir_o      (dir_all[s*SET_PINS +: SET_PINS]),
      .out_o      (pin_out[s*SET_PINS +: SET_PINS]),
      .rise_o     (rise_all[s*SET_PINS +: SET_PINS]),
      .fall_o     (fall_all[s*SET_PINS +: SET_PINS]),
      .stat_o     (status_all[s*SET_PINS +: SET_PINS])
    );
  end

  assign pin_oe = ~dir_all;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    assign bank_irq[b] = bank_en_q[b] && (|status_all[b*BANK_PINS +: BANK_PINS]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_en_q <= '0;
      rdata_q   <= '0;
      rvalid_q  <= 1'b0;
    end else begin
      if (bus_wen && hit_bank_en) bank_en_q <= bus_wdata[BANKS-1:0];
      rvalid_q <= bus_ren;
      if (bus_ren) begin
        if (hit_set)          rdata_q <= set_rd[set_idx];
        else if (hit_bank_en) rdata_q <= 32'(bank_en_q);
        else                  rdata_q <= '0;
      end
    end
  end

  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;
endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
module gpio_bank_ctrl_chk #(
  parameter int PINS  = 64,
  parameter int BANKS = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wen,
  input logic             bus_ren,
  input logic             bus_rvalid,
  input logic [PINS-1:0]  pin_out,
  input logic [PINS-1:0]  rise_all,
  input logic [PINS-1:0]  fall_all,
  input logic [PINS-1:0]  status_all,
  input logic [BANKS-1:0] bank_en,
  input logic [BANKS-1:0] bank_irq
);
  // R2: read data valid exactly one cycle after a read strobe
  p_rvalid_after_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ren |=> bus_rvalid);
  p_no_spurious_rvalid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ren |=> !bus_rvalid);

  // R4: outputs change only through a bus write
  p_out_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wen |=> $stable(pin_out));

  // R6: edge enables change only through a bus write
  p_enable_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wen |=> ($stable(rise_all) && $stable(fall_all)));

  // R8: status bits never drop without a write
  p_status_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wen |=> ((status_all & $past(status_all)) == $past(status_all)));

  // R9: a bank line is never high with its enable clear, or with no pending status
  p_irq_needs_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((bank_irq & ~bank_en) == '0));
  p_irq_needs_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (status_all == '0) |-> (bank_irq == '0));
endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(.PINS(PINS), .BANKS(BANKS)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_wen    (bus_wen),
  .bus_ren    (bus_ren),
  .bus_rvalid (bus_rvalid),
  .pin_out    (pin_out),
  .rise_all   (rise_all),
  .fall_all   (fall_all),
  .status_all (status_all),
  .bank_en    (bank_en_q),
  .bank_irq   (bank_irq)
);

// File: tb/gpio_bank_ctrl_tb_top.sv
module gpio_bank_ctrl_tb_top;
  import gpio_bank_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int NSETS = 2;
  localparam int PINS  = 32 * NSETS;
  localparam int BANKS = 2 * NSETS;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             bus_wen = 1'b0;
  logic             bus_ren = 1'b0;
  logic [7:0]       bus_addr = '0;
  logic [31:0]      bus_wdata = '0;
  logic [31:0]      bus_rdata;
  logic             bus_rvalid;
  logic [PINS-1:0]  pin_in = '0;
  logic [PINS-1:0]  pin_out;
  logic [PINS-1:0]  pin_oe;
  logic [BANKS-1:0] bank_irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_bank_ctrl #(.NUM_SETS(NSETS), .ADDR_W(8)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wen    (bus_wen),
    .bus_ren    (bus_ren),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid),
    .pin_in     (pin_in),
    .pin_out    (pin_out),
    .pin_oe     (pin_oe),
    .bank_irq   (bank_irq)
  );

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } exp_t;

  exp_t sb_q[$];
  int   n_run  = 0;
  int   n_fail = 0;
  bit   finished = 1'b0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] ra(int s, word_e w);
    return 8'(16 + 40 * s + 4 * int'(w));
  endfunction

  task automatic wr(logic [7:0] a, logic [31:0] d);
    bus_wen = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wen = 1'b0;
  endtask

  // driver: push the expected word, then issue the read
  task automatic rd(logic [7:0] a, logic [31:0] e, string tag);
    exp_t x;
    x.exp = e; x.tag = tag;
    sb_q.push_back(x);
    bus_ren = 1'b1; bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    bus_ren = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pop and compare whenever read data is presented
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      if (sb_q.size() == 0) begin
        n_run++; n_fail++;
        $display("FAIL R2: actual unexpected data %h expected no read data", bus_rdata);
      end else begin
        exp_t x;
        x = sb_q.pop_front();
        chk(x.tag, {32'b0, bus_rdata}, {32'b0, x.exp});
      end
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    chk("R1 pin_oe", 64'(pin_oe), 64'h0);
    chk("R1 pin_out", 64'(pin_out), 64'h0);
    chk("R1 bank_irq", 64'(bank_irq), 64'h0);
    rd(ra(0, W_DIR),  32'hFFFF_FFFF, "R1 dir set0");
    rd(ra(1, W_DIR),  32'hFFFF_FFFF, "R1 dir set1");
    rd(ra(1, W_OUT),  32'h0, "R1 out set1");
    rd(ra(0, W_SETR), 32'h0, "R1 rise set0");
    rd(ra(0, W_CLRF), 32'h0, "R1 fall set0");
    rd(ra(0, W_STAT), 32'h0, "R1 status set0");
    rd(8'h08,         32'h0, "R1 R2 bank enable");

    // R3 direction
    wr(ra(0, W_DIR), 32'hFFFF_FF00);
    chk("R3 pin_oe low half", 64'(pin_oe), 64'h0000_0000_0000_00FF);
    wr(ra(1, W_DIR), 32'h7FFF_FFFF);
    chk("R3 pin_oe set1", 64'(pin_oe), 64'h8000_0000_0000_00FF);

    // R4 output writes
    wr(ra(0, W_SETO), 32'h0000_00A5);
    chk("R4 set-output", 64'(pin_out), 64'h0000_0000_0000_00A5);
    wr(ra(0, W_CLRO), 32'h0000_0005);
    chk("R4 clear-output", 64'(pin_out), 64'h0000_0000_0000_00A0);
    wr(ra(1, W_SETO), 32'h8000_0001);
    chk("R4 set-output set1", 64'(pin_out), 64'h8000_0001_0000_00A0);
    wr(ra(1, W_OUT), 32'h0F00_0000);
    chk("R4 direct output write", 64'(pin_out), 64'h0F00_0000_0000_00A0);
    rd(ra(0, W_CLRO), 32'h0000_00A0, "R4 clear-output readback");
    rd(ra(1, W_OUT),  32'h0F00_0000, "R4 output readback");

    // R5 synchronised input level with two-cycle latency
    pin_in = 64'h0000_0000_1234_5678;
    rd(ra(0, W_IN), 32'h0, "R5 edge k old level");
    rd(ra(0, W_IN), 32'h0, "R5 edge k+1 old level");
    rd(ra(0, W_IN), 32'h1234_5678, "R5 edge k+2 new level incl output pins");
    wr(ra(0, W_IN), 32'hFFFF_FFFF);
    rd(ra(0, W_IN), 32'h1234_5678, "R5 input word ignores writes");
    pin_in = '0;
    idle(4);

    // R6 enable pairs
    wr(ra(0, W_SETR), 32'h0000_0003);
    wr(ra(0, W_SETF), 32'h0000_0002);
    rd(ra(0, W_SETR), 32'h0000_0003, "R6 rise after set");
    wr(ra(0, W_CLRR), 32'h0000_0001);
    rd(ra(0, W_CLRR), 32'h0000_0002, "R6 rise after clear");
    rd(ra(0, W_SETF), 32'h0000_0002, "R6 fall mask");
    rd(ra(0, W_STAT), 32'h0, "R7 no edges yet");

    // R7 edges: pin1 both edges, pin0 none
    pin_in[1:0] = 2'b11;
    idle(3);
    rd(ra(0, W_STAT), 32'h0000_0002, "R7 rising latched, disabled pin ignored");
    chk("R9 bank0 gated by enable", 64'(bank_irq), 64'h0);
    wr(8'h08, 32'h0000_0001);
    chk("R9 bank0 asserted", 64'(bank_irq), 64'h1);
    wr(ra(0, W_STAT), 32'h0000_0002);
    rd(ra(0, W_STAT), 32'h0, "R8 W1C clears");
    chk("R9 bank0 drops after clear", 64'(bank_irq), 64'h0);
    pin_in[1:0] = 2'b00;
    idle(3);
    rd(ra(0, W_STAT), 32'h0000_0002, "R7 falling latched");

    // R8 edge and clear in the same cycle: the edge wins
    pin_in[1] = 1'b1;
    idle(2);
    wr(ra(0, W_STAT), 32'h0000_0002);
    rd(ra(0, W_STAT), 32'h0000_0002, "R8 simultaneous edge wins");
    wr(ra(0, W_STAT), 32'h0000_0002);
    rd(ra(0, W_STAT), 32'h0, "R8 later clear");

    // R9 odd bank uses the high half-word of set1
    wr(ra(1, W_SETR), 32'h0001_0000);
    pin_in[48] = 1'b1;
    idle(3);
    rd(ra(1, W_STAT), 32'h0001_0000, "R7 set1 rising");
    chk("R9 bank3 gated by enable", 64'(bank_irq), 64'h0);
    wr(8'h08, 32'h0000_0009);
    chk("R9 only bank3 asserted", 64'(bank_irq), 64'h8);
    rd(8'h08, 32'h0000_0009, "R2 bank enable readback");

    // R10 unmapped addresses
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h60, 32'hFFFF_FFFF);
    wr(8'h11, 32'h0000_0000);
    chk("R10 outputs untouched", 64'(pin_out), 64'h0F00_0000_0000_00A0);
    chk("R10 directions untouched", 64'(pin_oe), 64'h8000_0000_0000_00FF);
    chk("R10 bank lines untouched", 64'(bank_irq), 64'h8);
    rd(8'h0C, 32'h0, "R10 gap reads zero");
    rd(8'h60, 32'h0, "R10 beyond last set reads zero");
    rd(8'h15, 32'h0, "R10 unaligned reads zero");

    idle(3);
    chk("R2 every read answered", 64'(sb_q.size()), 64'h0);
    summary();
  end
endmodule